// File: doc/BRIEF.md
# TLB Lockdown Entry Access Port

This block gives software a register path for saving and restoring a small array of locked address-translation entries. Each entry holds a virtual page, a physical page, a page size, an access-permission code, a valid flag and a 12-bit attribute word. Software first loads the write-select index. It then stages the virtual-address word and the attribute word, and it finishes by writing the physical-address word. That last write is the commit point. It places the staged fields and the physical-address fields into the chosen slot in one step.

Reads use a separate read-select index. This lets a save routine walk the array while a restore routine has a write target already loaded. Page bits below the page granularity are cleared when an entry is stored. A reserved permission code, or a write index beyond the array, causes the commit to be dropped. The bus has separate write and read strobes, each with its own 3-bit address. Read data is registered.

Top module: `tlbl_port`

## Requirements
- R1: The read-select index sits at address 0 and the write-select index at address 1. Each is SEL_W bits wide and reads back zero-extended. A read of addresses 5 to 7 returns zero, and a write to them changes nothing.
- R2: A write to address 2 (virtual-address word) or to address 4 (attribute word) only loads a staging register. The stored entries do not change until a commit.
- R3: A write to address 3 (physical-address word) stores the staged virtual-address fields, the staged attribute word and the written physical-address fields into the entry named by the write-select index, all in one clock edge.
- R4: The virtual-address word packs the page number in bits 31:12, the non-secure flag in bit 10 and the 8-bit space identifier in bits 7:0. Bits 11, 9 and 8 read as zero.
- R5: The physical-address word packs the page number in bits 31:12, the size in bits 7:6 (00 = 16MB, 01 = 4KB, 10 = 64KB, 11 = 1MB), the permission code in bits 3:1 and the locked-valid flag in bit 0. All other bits read as zero.
- R6: At commit, both page numbers are cleared below the page granularity. No bits are cleared for 4KB. Bits 15:12 are cleared for 64KB, bits 19:12 for 1MB and bits 23:12 for 16MB.
- R7: The attribute word keeps bits 11:0: non-secure in 11, domain in 10:7, execute-never in 6, region type in 5:1 and shared in 0. Bits 31:12 read as zero.
- R8: A physical-address write whose permission code (bits 3:1) is 100 commits nothing.
- R9: A physical-address write while the write-select index is N_ENTRIES or more commits nothing.
- R10: While the read-select index is N_ENTRIES or more, reads of addresses 2, 3 and 4 return zero.
- R11: rd_data takes the selected value on the clock edge that samples rd_en, and it holds that value while rd_en is low. A read and a commit to the same entry on the same edge return the entry's contents from before the commit.
- R12: After reset, every entry, both staging registers, both indexes and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |

## Verification
A commit into a slot and a read of that same slot can land on one clock edge, because the two strobes are independent. The bench provokes this by pointing both indexes at one entry. It then asserts a physical-address write and a physical-address read in the same cycle. It judges the result by requiring the old physical word in rd_data, and then the new word on the next read.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;

   localparam int DW     = 32;
   localparam int PG_W   = 20;
   localparam int SPID_W = 8;
   localparam int ATTR_W = 12;

   typedef enum logic [2:0] {
      A_RSEL = 3'd0,
      A_WSEL = 3'd1,
      A_VA   = 3'd2,
      A_PA   = 3'd3,
      A_ATTR = 3'd4
   } reg_addr_e;

   typedef enum logic [1:0] {
      SZ_16M = 2'b00,
      SZ_4K  = 2'b01,
      SZ_64K = 2'b10,
      SZ_1M  = 2'b11
   } pg_size_e;

   localparam logic [2:0] AP_RSVD = 3'b100;

   typedef struct packed {
      logic [PG_W-1:0]   vpn;
      logic              nsec;
      logic [SPID_W-1:0] spid;
   } va_t;

   typedef struct packed {
      logic [PG_W-1:0] ppn;
      pg_size_e        size;
      logic [2:0]      perm;
      logic            lv;
   } pa_t;

   typedef struct packed {
      va_t               va;
      pa_t               pa;
      logic [ATTR_W-1:0] attr;
   } ent_t;

   localparam int ENT_W = $bits(ent_t);

   // page-number bits kept for each granularity
   function automatic logic [PG_W-1:0] page_keep(pg_size_e sz);
      case (sz)
         SZ_4K:   page_keep = {PG_W{1'b1}};
         SZ_64K:  page_keep = {{(PG_W-4){1'b1}}, 4'b0};
         SZ_1M:   page_keep = {{(PG_W-8){1'b1}}, 8'b0};
         default: page_keep = {{(PG_W-12){1'b1}}, 12'b0};
      endcase
   endfunction

   function automatic logic [DW-1:0] pack_va(va_t v);
      pack_va = {v.vpn, 1'b0, v.nsec, 2'b00, v.spid};
   endfunction

   function automatic logic [DW-1:0] pack_pa(pa_t p);
      pack_pa = {p.ppn, 4'b0, p.size, 2'b00, p.perm, p.lv};
   endfunction

   function automatic logic [DW-1:0] pack_attr(logic [ATTR_W-1:0] a);
      pack_attr = {{(DW-ATTR_W){1'b0}}, a};
   endfunction

endpackage

// File: rtl/tlbl_ctrl.sv
module tlbl_ctrl
   import tlbl_pkg::*;
#(
   parameter int N_ENTRIES = 4,
   parameter int SEL_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [DW-1:0]    wr_data,
   output logic [SEL_W-1:0] rsel_q,
   output logic [SEL_W-1:0] wsel_q,
   output logic             commit_en,
   output ent_t             commit_ent
);

   localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(N_ENTRIES);

   va_t               stg_va;
   logic [ATTR_W-1:0] stg_attr;
   pg_size_e          wr_size;
   logic [PG_W-1:0]   keep;
   logic              w_in_range;
   logic              perm_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel_q   <= '0;
         wsel_q   <= '0;
         stg_va   <= '0;
         stg_attr <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_RSEL: rsel_q <= wr_data[SEL_W-1:0];
            A_WSEL: wsel_q <= wr_data[SEL_W-1:0];
            A_VA: begin
               stg_va.vpn  <= wr_data[31:12];
               stg_va.nsec <= wr_data[10];
               stg_va.spid <= wr_data[SPID_W-1:0];
            end
            A_ATTR:  stg_attr <= wr_data[ATTR_W-1:0];
            default: ;
         endcase
      end
   end

   assign wr_size    = pg_size_e'(wr_data[7:6]);
   assign keep       = page_keep(wr_size);
   assign w_in_range = ({1'b0, wsel_q} < LIMIT);
   assign perm_ok    = (wr_data[3:1] != AP_RSVD);
   assign commit_en  = wr_en && (wr_addr == A_PA) && perm_ok && w_in_range;

   always_comb begin
      commit_ent         = '0;
      commit_ent.va.vpn  = stg_va.vpn & keep;
      commit_ent.va.nsec = stg_va.nsec;
      commit_ent.va.spid = stg_va.spid;
      commit_ent.pa.ppn  = wr_data[31:12] & keep;
      commit_ent.pa.size = wr_size;
      commit_ent.pa.perm = wr_data[3:1];
      commit_ent.pa.lv   = wr_data[0];
      commit_ent.attr    = stg_attr;
   end

endmodule

// File: rtl/tlbl_store.sv
module tlbl_store
   import tlbl_pkg::*;
#(
   parameter int N_ENTRIES = 4,
   parameter int SEL_W     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [SEL_W-1:0]         widx,
   input  ent_t                     wdat,
   output logic [N_ENTRIES*ENT_W-1:0] ent_flat
);

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
      ent_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (we && (widx == SEL_W'(g)))
            slot_q <= wdat;
      end
      assign ent_flat[g*ENT_W +: ENT_W] = slot_q;
   end

endmodule

// File: rtl/tlbl_rdsel.sv
module tlbl_rdsel
   import tlbl_pkg::*;
#(
   parameter int N_ENTRIES = 4,
   parameter int SEL_W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_en,
   input  logic [2:0]                 rd_addr,
   input  logic [SEL_W-1:0]           rsel,
   input  logic [SEL_W-1:0]           wsel,
   input  logic [N_ENTRIES*ENT_W-1:0] ent_flat,
   output logic [DW-1:0]              rd_data
);

   ent_t          slot [N_ENTRIES];
   ent_t          pick;
   logic [DW-1:0] rd_next;

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_tap
      assign slot[g] = ent_t'(ent_flat[g*ENT_W +: ENT_W]);
   end

   // an index past the array matches no slot and leaves pick at zero
   always_comb begin
      pick = '0;
      for (int i = 0; i < N_ENTRIES; i++)
         if (rsel == SEL_W'(i)) pick = slot[i];
   end

   always_comb begin
      case (rd_addr)
         A_RSEL:  rd_next = {{(DW-SEL_W){1'b0}}, rsel};
         A_WSEL:  rd_next = {{(DW-SEL_W){1'b0}}, wsel};
         A_VA:    rd_next = pack_va(pick.va);
         A_PA:    rd_next = pack_pa(pick.pa);
         A_ATTR:  rd_next = pack_attr(pick.attr);
         default: rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_next;
   end

endmodule

// File: rtl/tlbl_port.sv
module tlbl_port
   import tlbl_pkg::*;
#(
   parameter int N_ENTRIES = 4,
   parameter int SEL_W     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [31:0]   wr_data,
   input  logic          rd_en,
   input  logic [2:0]    rd_addr,
   output logic [31:0]   rd_data
);

   if (N_ENTRIES < 1) begin : g_bad_depth
      $error("tlbl_port: N_ENTRIES must be at least 1");
   end
   if (SEL_W < 1 || SEL_W >= DW) begin : g_bad_selw
      $error("tlbl_port: SEL_W must lie in 1..31");
   end
   if (N_ENTRIES > (1 << SEL_W)) begin : g_bad_reach
      $error("tlbl_port: SEL_W cannot address every entry");
   end

   logic [SEL_W-1:0]           rsel_q;
   logic [SEL_W-1:0]           wsel_q;
   logic                       commit_en;
   ent_t                       commit_ent;
   logic [N_ENTRIES*ENT_W-1:0] ent_flat;

   tlbl_ctrl #(.N_ENTRIES(N_ENTRIES), .SEL_W(SEL_W)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rsel_q     (rsel_q),
      .wsel_q     (wsel_q),
      .commit_en  (commit_en),
      .commit_ent (commit_ent)
   );

   tlbl_store #(.N_ENTRIES(N_ENTRIES), .SEL_W(SEL_W)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (commit_en),
      .widx     (wsel_q),
      .wdat     (commit_ent),
      .ent_flat (ent_flat)
   );

   tlbl_rdsel #(.N_ENTRIES(N_ENTRIES), .SEL_W(SEL_W)) rdsel_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rsel     (rsel_q),
      .wsel     (wsel_q),
      .ent_flat (ent_flat),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/tlbl_port_chk.sv
module tlbl_port_chk
   import tlbl_pkg::*;
#(
   parameter int N_ENTRIES = 4,
   parameter int SEL_W     = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [2:0]                 wr_addr,
   input logic [31:0]                wr_data,
   input logic                       rd_en,
   input logic [2:0]                 rd_addr,
   input logic [31:0]                rd_data,
   input logic [SEL_W-1:0]           rsel_q,
   input logic [SEL_W-1:0]           wsel_q,
   input logic [N_ENTRIES*ENT_W-1:0] ent_flat
);

   localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(N_ENTRIES);

   logic w_oob, r_oob, rd_entry;
   assign w_oob    = ({1'b0, wsel_q} >= LIMIT);
   assign r_oob    = ({1'b0, rsel_q} >= LIMIT);
   assign rd_entry = (rd_addr == A_VA) || (rd_addr == A_PA) || (rd_addr == A_ATTR);

   a_r1_rsel_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_RSEL) |=> (rsel_q == $past(wr_data[SEL_W-1:0])));

   a_r2_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == A_VA || wr_addr == A_ATTR)) |=> $stable(ent_flat));

   a_r4_va_gaps_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == A_VA) |=> (rd_data[11] == 1'b0 && rd_data[9:8] == 2'b00));

   a_r7_attr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == A_ATTR) |=> (rd_data[31:12] == '0));

   a_r8_rsvd_perm_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_PA && wr_data[3:1] == 3'b100) |=> $stable(ent_flat));

   a_r9_oob_write_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_PA && w_oob) |=> $stable(ent_flat));

   a_r10_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_entry && r_oob) |=> (rd_data == '0));

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   a_r12_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_data == '0 && ent_flat == '0));

endmodule

bind tlbl_port tlbl_port_chk #(.N_ENTRIES(N_ENTRIES), .SEL_W(SEL_W)) chk_i (.*);

// File: tb/tlbl_port_tb_top.sv
module tlbl_port_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 41;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlbl_port #(.N_ENTRIES(4), .SEL_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // rd = 1: read and compare d; rd = 0: write d
   typedef struct packed {
      logic        rd;
      logic [2:0]  a;
      logic [31:0] d;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      '{1'b0, 3'd1, 32'h0000_0001, 4'd1},   // R1 write index 1
      '{1'b0, 3'd2, 32'hFFFF_F7FF, 4'd2},
      '{1'b0, 3'd4, 32'hFFFF_FFFF, 4'd2},
      '{1'b0, 3'd3, 32'h1234_5F47, 4'd3},   // R3 commit 4KB
      '{1'b0, 3'd0, 32'h0000_0001, 4'd1},
      '{1'b1, 3'd0, 32'h0000_0001, 4'd1},   // R1
      '{1'b1, 3'd1, 32'h0000_0001, 4'd1},   // R1
      '{1'b1, 3'd2, 32'hFFFF_F4FF, 4'd4},   // R4
      '{1'b1, 3'd4, 32'h0000_0FFF, 4'd7},   // R7
      '{1'b1, 3'd3, 32'h1234_5047, 4'd5},   // R5
      '{1'b0, 3'd2, 32'h0000_0000, 4'd2},   // R2 stage without commit
      '{1'b0, 3'd4, 32'h0000_0000, 4'd2},
      '{1'b1, 3'd2, 32'hFFFF_F4FF, 4'd2},   // R2
      '{1'b1, 3'd4, 32'h0000_0FFF, 4'd2},   // R2
      '{1'b0, 3'd1, 32'h0000_0002, 4'd6},   // R6 64KB
      '{1'b0, 3'd2, 32'hABCD_E5A5, 4'd6},
      '{1'b0, 3'd4, 32'h0000_0A5A, 4'd7},
      '{1'b0, 3'd3, 32'h9876_508B, 4'd6},
      '{1'b0, 3'd0, 32'h0000_0002, 4'd1},
      '{1'b1, 3'd2, 32'hABCD_04A5, 4'd6},
      '{1'b1, 3'd4, 32'h0000_0A5A, 4'd7},
      '{1'b1, 3'd3, 32'h9876_008B, 4'd6},
      '{1'b0, 3'd1, 32'h0000_0003, 4'd6},   // R6 1MB
      '{1'b0, 3'd2, 32'h1357_9BDF, 4'd6},
      '{1'b0, 3'd4, 32'h1234_5678, 4'd7},
      '{1'b0, 3'd3, 32'h2468_ACC3, 4'd6},
      '{1'b0, 3'd0, 32'h0000_0003, 4'd1},
      '{1'b1, 3'd2, 32'h1350_00DF, 4'd6},
      '{1'b1, 3'd4, 32'h0000_0678, 4'd7},
      '{1'b1, 3'd3, 32'h2460_00C3, 4'd6},
      '{1'b0, 3'd1, 32'h0000_0000, 4'd6},   // R6 16MB
      '{1'b0, 3'd2, 32'hFEDC_BA98, 4'd6},
      '{1'b0, 3'd4, 32'h0000_0801, 4'd7},
      '{1'b0, 3'd3, 32'h7654_320F, 4'd6},
      '{1'b0, 3'd0, 32'h0000_0000, 4'd1},
      '{1'b1, 3'd2, 32'hFE00_0098, 4'd6},
      '{1'b1, 3'd4, 32'h0000_0801, 4'd7},
      '{1'b1, 3'd3, 32'h7600_000F, 4'd6},
      '{1'b1, 3'd5, 32'h0000_0000, 4'd1},   // R1 unused address
      '{1'b0, 3'd6, 32'hFFFF_FFFF, 4'd1},
      '{1'b1, 3'd0, 32'h0000_0000, 4'd1}    // R1 unused write ignored
   };

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(logic [2:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      check(tag, rd_data, exp);
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 rd_data after reset", rd_data, 32'h0);
      do_rd(3'd0, 32'h0, "R12 read index");
      do_rd(3'd3, 32'h0, "R12 entry0 PA");
      do_rd(3'd2, 32'h0, "R12 entry0 VA");

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd)
            do_rd(VEC[i].a, VEC[i].d, $sformatf("R%0d vec%0d", VEC[i].req, i));
         else
            do_wr(VEC[i].a, VEC[i].d);
      end

      // R8: reserved permission code, entry 2 must keep its contents
      do_wr(3'd1, 32'h2);
      do_wr(3'd2, 32'h0);
      do_wr(3'd4, 32'h0);
      do_wr(3'd3, 32'h0000_0009);
      do_wr(3'd0, 32'h2);
      do_rd(3'd3, 32'h9876_008B, "R8 PA kept");
      do_rd(3'd2, 32'hABCD_04A5, "R8 VA kept");

      // R9: write index past the array
      do_wr(3'd1, 32'h4);
      do_wr(3'd3, 32'h0000_0047);
      do_wr(3'd0, 32'h0); do_rd(3'd3, 32'h7600_000F, "R9 entry0");
      do_wr(3'd0, 32'h1); do_rd(3'd3, 32'h1234_5047, "R9 entry1");
      do_wr(3'd0, 32'h2); do_rd(3'd3, 32'h9876_008B, "R9 entry2");
      do_wr(3'd0, 32'h3); do_rd(3'd3, 32'h2460_00C3, "R9 entry3");

      // R10: read index past the array
      do_wr(3'd0, 32'h7);
      do_rd(3'd2, 32'h0, "R10 VA");
      do_rd(3'd3, 32'h0, "R10 PA");
      do_rd(3'd4, 32'h0, "R10 ATTR");
      do_rd(3'd0, 32'h7, "R10 index readback");

      // R11: commit and read of entry 3 on one edge
      do_wr(3'd1, 32'h3);
      do_wr(3'd2, 32'h1111_1000);
      do_wr(3'd4, 32'h0);
      do_wr(3'd0, 32'h3);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h1111_1047;
      rd_en = 1'b1; rd_addr = 3'd3;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R11 same-edge read old", rd_data, 32'h2460_00C3);
      do_rd(3'd3, 32'h1111_1047, "R11 new PA");
      do_rd(3'd2, 32'h1111_1000, "R11 new VA");
      repeat (3) @(negedge clk);
      check("R11 hold", rd_data, 32'h1111_1000);

      done = 1;
      report();
   end

endmodule